// File: doc/BRIEF.md
# Configuration Target Decoder for a Bus Bridge

This block sits on the upstream side of a bus bridge. It watches every address phase on the upstream bus and decides whether the cycle is a local configuration access the bridge should claim. A cycle is claimed only if four conditions all hold. The command must be configuration read or configuration write. The two lowest address bits must be zero. The chip-select for configuration must be asserted. The cycle must not come from the downstream side. When the block claims a cycle, it drives the target handshake (DEVSEL, TRDY, STOP) and moves exactly one DWORD to or from a register file attached to it.

The register file is outside this block. For reads, the block issues a read strobe and a DWORD index. It then returns the full 32-bit word the register file supplies. For writes, it issues a write strobe with the data and a byte mask. Configuration cycles never pass through the bridge's posting buffers, and there are no wait states. TRDY is asserted in the same cycle as DEVSEL. If the initiator asks for a burst, the block disconnects after the first DWORD.

Top module: `cfg0_target`

## Requirements
- R1: A cycle is claimed only when C/BE# during the address phase carries 4'b1010 (configuration read) or 4'b1011 (configuration write); any other command leaves DEVSEL, TRDY and STOP deasserted and produces no register strobe.
- R2: A cycle is claimed only when AD[1:0] is 2'b00 during the address phase. A value such as 2'b01 is not claimed.
- R3: A cycle is claimed only when the configuration chip-select input is high during the address phase.
- R4: When the side indicator is high (cycle seen on the downstream side), no cycle is claimed, even if all other conditions hold.
- R5: Medium decode timing applies. The address phase is the first clock edge with FRAME# low after FRAME# was high. DEVSEL# stays high after that edge and goes low after the next edge. TRDY# goes low in the same cycle as DEVSEL#, with no wait states.
- R6: Only one DWORD moves per cycle. If FRAME# is still low at the edge where DEVSEL# is asserted, STOP# goes low together with TRDY#. After the data transfer (an edge with IRDY# and TRDY# both low), TRDY# rises. STOP# and DEVSEL# stay low until the end condition in R9.
- R7: For a read, the read strobe is high for one cycle between the address edge and the DEVSEL edge, with the DWORD index equal to AD[7:2]. While TRDY# is low, all 32 bits the register file returned are driven, with the output enable high, whatever the data-phase byte enables are.
- R8: For a write, the write strobe is high for exactly one cycle, right after the transfer edge. It carries the AD value from that edge, the byte mask equal to the inverse of C/BE# at that edge (bit n high means byte n is written), and the DWORD index from AD[7:2].
- R9: All target signals are released (DEVSEL#, TRDY#, STOP# high, output enable low) after the first edge that finds FRAME# and IRDY# both high. They are also released at the transfer edge if FRAME# is already high there.
- R10: While reset is active and just after it, DEVSEL#, TRDY# and STOP# are high and the output enable, read strobe and write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Sampled AD bus |
| cbe_n | input | 4 | Sampled command / byte enables, active low |
| idsel | input | 1 | Configuration chip-select |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| from_downstream | input | 1 | High when the cycle was seen on the downstream side |
| devsel_n | output | 1 | Target select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop (disconnect), active low |
| ad_out | output | 32 | Read data toward the AD bus |
| ad_oe | output | 1 | Output enable for ad_out |
| reg_rd | output | 1 | Register-file read strobe |
| reg_wr | output | 1 | Register-file write strobe |
| reg_idx | output | 6 | DWORD index into the register file |
| reg_be | output | 4 | Write byte mask, active high |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the register file |

## Verification
The hardest case to reach is the disconnect path. Here the initiator keeps FRAME# low through the transfer edge, the block sits with STOP# and DEVSEL# low but TRDY# high, and it must wait for FRAME# and then IRDY# to rise. The burst variants of the read and write tasks hold FRAME# low across the first data edge. They then raise FRAME# one cycle before IRDY#, so the bench can see that DEVSEL# survives the intermediate cycle and is released only on the edge that finds both high. The single-phase variants cover release at the transfer edge itself.

// File: rtl/cfg0_pkg.sv
package cfg0_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_DATA   = 2'd2,
        ST_HOLD   = 2'd3
    } tgt_state_e;
endpackage

// File: rtl/cfg0_frame_mon.sv
module cfg0_frame_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    output logic addr_phase
);
    logic frame_d, frame_q;

    always_comb begin
        frame_d    = frame_n;
        addr_phase = frame_q & ~frame_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= frame_d;
    end

    // R5
    addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> !addr_phase);
endmodule

// File: rtl/cfg0_decode.sv
module cfg0_decode #(
    parameter logic [3:0] CMD_RD = 4'b1010,
    parameter logic [3:0] CMD_WR = 4'b1011
) (
    input  logic [1:0] ad_low,
    input  logic [3:0] cmd,
    input  logic       idsel,
    input  logic       from_downstream,
    output logic       claim,
    output logic       is_write
);
    logic cmd_ok;

    always_comb begin
        cmd_ok   = (cmd == CMD_RD) || (cmd == CMD_WR);
        is_write = (cmd == CMD_WR);
        claim    = cmd_ok && (ad_low == 2'b00) && idsel && !from_downstream;
    end
endmodule

// File: rtl/cfg0_target.sv
module cfg0_target #(
    parameter int         AD_W    = 32,
    parameter int         IDX_W   = 6,
    parameter int         IDX_LSB = 2,
    parameter logic [3:0] CMD_RD  = 4'b1010,
    parameter logic [3:0] CMD_WR  = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AD_W-1:0]   ad_in,
    input  logic [3:0]        cbe_n,
    input  logic              idsel,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              from_downstream,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [3:0]        reg_be,
    output logic [AD_W-1:0]   reg_wdata,
    input  logic [AD_W-1:0]   reg_rdata
);
    import cfg0_pkg::*;

    localparam int BE_W = AD_W / 8;

    typedef struct packed {
        tgt_state_e        st;
        logic              devsel_n;
        logic              trdy_n;
        logic              stop_n;
        logic              ad_oe;
        logic              is_wr;
        logic              wr_stb;
        logic [IDX_W-1:0]  idx;
        logic [BE_W-1:0]   be;
        logic [AD_W-1:0]   wdata;
        logic [AD_W-1:0]   rdata;
    } tgt_regs_t;

    tgt_regs_t q, d;
    logic addr_phase, claim, dec_wr;

    cfg0_frame_mon u_frame_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .addr_phase (addr_phase)
    );

    cfg0_decode #(.CMD_RD(CMD_RD), .CMD_WR(CMD_WR)) u_decode (
        .ad_low          (ad_in[1:0]),
        .cmd             (cbe_n),
        .idsel           (idsel),
        .from_downstream (from_downstream),
        .claim           (claim),
        .is_write        (dec_wr)
    );

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (addr_phase && claim) begin
                    d.st    = ST_DECODE;
                    d.idx   = ad_in[IDX_LSB +: IDX_W];
                    d.is_wr = dec_wr;
                end
            end
            ST_DECODE: begin
                d.st       = ST_DATA;
                d.devsel_n = 1'b0;
                d.trdy_n   = 1'b0;
                d.stop_n   = frame_n;
                d.ad_oe    = !q.is_wr;
                d.rdata    = reg_rdata;
            end
            ST_DATA: begin
                if (!irdy_n) begin
                    d.trdy_n = 1'b1;
                    d.ad_oe  = 1'b0;
                    if (q.is_wr) begin
                        d.wr_stb = 1'b1;
                        d.wdata  = ad_in;
                        d.be     = ~cbe_n;
                    end
                    if (frame_n) begin
                        d.st       = ST_IDLE;
                        d.devsel_n = 1'b1;
                        d.stop_n   = 1'b1;
                    end else begin
                        d.st     = ST_HOLD;
                        d.stop_n = 1'b0;
                    end
                end
            end
            ST_HOLD: begin
                if (frame_n && irdy_n) begin
                    d.st       = ST_IDLE;
                    d.devsel_n = 1'b1;
                    d.stop_n   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.devsel_n <= 1'b1;
            q.trdy_n   <= 1'b1;
            q.stop_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        devsel_n  = q.devsel_n;
        trdy_n    = q.trdy_n;
        stop_n    = q.stop_n;
        ad_oe     = q.ad_oe;
        ad_out    = q.rdata;
        reg_rd    = (q.st == ST_DECODE) && !q.is_wr;
        reg_wr    = q.wr_stb;
        reg_idx   = q.idx;
        reg_be    = q.be;
        reg_wdata = q.wdata;
    end

    // R5
    claim_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && claim && q.st == ST_IDLE) |=> devsel_n ##1 (!devsel_n && !trdy_n));
    // R4
    downstream_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && from_downstream && q.st == ST_IDLE) |=> ##1 devsel_n);
    // R6
    trdy_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);
    // R6
    stop_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);
    // R8
    wr_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(!trdy_n && !irdy_n));
    // R7
    oe_with_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!trdy_n && !devsel_n));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && trdy_n && frame_n && irdy_n) |=> (devsel_n && stop_n));
endmodule

// File: tb/cfg0_target_tb_top.sv
module cfg0_target_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        idsel = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        from_downstream = 1'b0;
    logic        devsel_n, trdy_n, stop_n, ad_oe, reg_rd, reg_wr;
    logic [31:0] ad_out, reg_wdata, reg_rdata;
    logic [5:0]  reg_idx;
    logic [3:0]  reg_be;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [31:0] model_rdata(input logic [5:0] i);
        return {8'hC3, 2'b00, i, 8'h5A, 2'b00, ~i};
    endfunction

    assign reg_rdata = model_rdata(reg_idx);

    cfg0_target dut_i (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n), .idsel(idsel),
        .frame_n(frame_n), .irdy_n(irdy_n), .from_downstream(from_downstream),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) if (rst_n && reg_wr) wr_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [3:0] cmd, input logic [31:0] ad,
                              input logic sel, input logic ds);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = ad; cbe_n = cmd;
        idsel = sel; from_downstream = ds;
    endtask

    task automatic ignored_case(input string req, input logic [3:0] cmd,
                                input logic [1:0] low, input logic sel, input logic ds);
        int w0;
        w0 = wr_seen;
        addr_phase(cmd, {24'h0, 6'd5, low}, sel, ds);
        @(negedge clk);
        ad_in = 32'h1234_5678; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = 1'b1;
        idsel = 1'b0; from_downstream = 1'b0;
        chk(req, {31'd0, reg_rd}, 32'd0);
        @(negedge clk);
        chk(req, {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        @(negedge clk);
        chk(req, {30'd0, devsel_n, ad_oe}, 32'd2);
        irdy_n = 1'b1;
        @(negedge clk);
        chk(req, wr_seen - w0, 32'd0);
    endtask

    task automatic write_case(input logic [5:0] idx, input logic [31:0] data,
                              input logic [3:0] be_n, input bit burst);
        addr_phase(4'b1011, {24'h0, idx, 2'b00}, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 devsel late", {31'd0, devsel_n}, 32'd1);
        ad_in = data; cbe_n = be_n; irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; idsel = 1'b0;
        @(negedge clk);
        chk("R5 devsel/trdy", {30'd0, devsel_n, trdy_n}, 32'd0);
        chk("R6 stop", {31'd0, stop_n}, burst ? 32'd0 : 32'd1);
        @(negedge clk);
        chk("R8 strobe", {31'd0, reg_wr}, 32'd1);
        chk("R8 data", reg_wdata, data);
        chk("R8 mask", {28'd0, reg_be}, {28'd0, ~be_n});
        chk("R8 idx", {26'd0, reg_idx}, {26'd0, idx});
        if (!burst) begin
            chk("R9 single release", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
            irdy_n = 1'b1;
            @(negedge clk);
            chk("R8 one cycle", {31'd0, reg_wr}, 32'd0);
        end else begin
            chk("R6 hold", {29'd0, devsel_n, trdy_n, stop_n}, 32'd2);
            frame_n = 1'b1;
            @(negedge clk);
            chk("R8 one cycle", {31'd0, reg_wr}, 32'd0);
            chk("R9 wait irdy", {30'd0, devsel_n, stop_n}, 32'd0);
            irdy_n = 1'b1;
            @(negedge clk);
            chk("R9 release", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        end
    endtask

    task automatic read_case(input logic [5:0] idx, input logic [3:0] be_n, input bit burst);
        addr_phase(4'b1010, {16'h0, 8'h00, idx, 2'b00}, 1'b1, 1'b0);
        @(negedge clk);
        chk("R7 rd strobe", {31'd0, reg_rd}, 32'd1);
        chk("R7 idx", {26'd0, reg_idx}, {26'd0, idx});
        chk("R5 devsel late", {31'd0, devsel_n}, 32'd1);
        ad_in = 32'hFFFF_FFFF; cbe_n = be_n; irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; idsel = 1'b0;
        @(negedge clk);
        chk("R7 rd strobe off", {31'd0, reg_rd}, 32'd0);
        chk("R5 devsel/trdy", {30'd0, devsel_n, trdy_n}, 32'd0);
        chk("R6 stop", {31'd0, stop_n}, burst ? 32'd0 : 32'd1);
        chk("R7 oe", {31'd0, ad_oe}, 32'd1);
        chk("R7 full dword", ad_out, model_rdata(idx));
        @(negedge clk);
        chk("R7 oe off", {30'd0, ad_oe, reg_wr}, 32'd0);
        if (!burst) begin
            chk("R9 single release", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
            irdy_n = 1'b1;
        end else begin
            chk("R6 hold", {29'd0, devsel_n, trdy_n, stop_n}, 32'd2);
            frame_n = 1'b1;
            @(negedge clk);
            chk("R9 wait irdy", {30'd0, devsel_n, stop_n}, 32'd0);
            irdy_n = 1'b1;
            @(negedge clk);
            chk("R9 release", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset", {26'd0, devsel_n, trdy_n, stop_n, ad_oe, reg_rd, reg_wr}, 32'h38);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {26'd0, devsel_n, trdy_n, stop_n, ad_oe, reg_rd, reg_wr}, 32'h38);
        write_case(6'd3, 32'hDEAD_BEEF, 4'b0000, 1'b0);
        write_case(6'd17, 32'h0102_0304, 4'b1010, 1'b1);
        read_case(6'd9, 4'b1110, 1'b0);
        read_case(6'd42, 4'b1111, 1'b1);
        ignored_case("R1 mem read cmd", 4'b0110, 2'b00, 1'b1, 1'b0);
        ignored_case("R1 io write cmd", 4'b0011, 2'b00, 1'b1, 1'b0);
        ignored_case("R2 type1 low bits", 4'b1011, 2'b01, 1'b1, 1'b0);
        ignored_case("R3 no idsel", 4'b1010, 2'b00, 1'b0, 1'b0);
        ignored_case("R4 downstream", 4'b1011, 2'b00, 1'b1, 1'b1);
        write_case(6'd63, 32'hA5A5_5A5A, 4'b0111, 1'b0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule